// File: doc/BRIEF.md
# Two-Thread Two-Port In-Order Issue Stage

This block is the issue stage of a core that runs two hardware threads and can start two operations per clock. Decoded micro-operations arrive on two intake lanes. Each one carries an operation class, a thread number and an opaque payload. The block stores each operation in a queue that belongs only to its thread. Every cycle it picks up to two stored operations and places them on execution port 0 and execution port 1.

The two ports can run different operation classes. Some classes fit only one of the ports. A floating-point add with a memory operand takes both ports in the same cycle. The threads share the ports. A rotating preference settles which thread goes first when both of them are eligible. Each thread issues strictly in its own program order. A per-thread readiness input lets the surrounding core hold a thread back.

Top module: `dual_issue_sched`

## Requirements
- R1: Lane 0 has its `in_ready[0]` high exactly when its thread's queue holds fewer than DEPTH entries. Lane 1 has its `in_ready[1]` high when its thread's queue, plus one more entry if lane 0 is valid, has room and targets the same thread, holds fewer than DEPTH entries. A lane's operation is stored only when its valid and ready are both high. Lane 0 counts as older than lane 1.
- R2: The two thread queues are independent. When one thread holds DEPTH entries, that thread's lanes are refused. Lanes that target the other thread are still accepted.
- R3: Operations of one thread issue in the order they were accepted. A younger operation of a thread issues in a cycle only when every older operation of that thread has already issued or issues in that same cycle.
- R4: The class is a 3-bit code: 0 simple ALU, 1 shift/rotate, 2 load/store, 3 bit manipulation, 4 jump, 5 address generation, 6 64-bit integer vector, 7 FP add with memory operand. Port 0 carries only codes 0, 1, 2, 6 and 7. Port 1 carries only codes 0, 3, 4, 5 and 7.
- R5: Code 6 (64-bit integer vector) never issues on port 1.
- R6: A code 7 operation issues on both ports in the same cycle, with the same thread and payload on each. No other operation issues in that cycle.
- R7: A thread whose `thr_rdy` bit is low, or whose queue is empty, issues nothing. Its operations stay queued.
- R8: A thread is eligible when its `thr_rdy` bit is high and its queue is not empty. The favoured thread's oldest operation issues first. In every cycle where both threads are eligible, the favour passes to the other thread for the next cycle.
- R9: After the first pick, the port it left free goes to the other eligible thread's oldest operation if that operation fits the free port. Failing that, the port goes to the first thread's second-oldest operation if that one fits. Otherwise the free port stays idle.
- R10: A code 0 operation taken as the first pick goes on port 1. Any other single-port-capable first pick goes on the only port its class allows.
- R11: Synchronous active-high `rst` empties both queues and gives the favour to thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Intake valid, one bit per lane |
| in_tid | input | 2 | Thread number, one bit per lane |
| in_cls | input | 6 | Class code, lane k at bits [3k+2:3k] |
| in_op | input | 2*OPW | Payload, lane k at bits [OPW*k+OPW-1:OPW*k] |
| in_ready | output | 2 | Intake ready, one bit per lane |
| thr_rdy | input | 2 | Per-thread permission to issue |
| p0_valid | output | 1 | Port 0 carries an operation |
| p0_tid | output | 1 | Port 0 thread tag |
| p0_cls | output | 3 | Port 0 class code |
| p0_op | output | OPW | Port 0 payload |
| p1_valid | output | 1 | Port 1 carries an operation |
| p1_tid | output | 1 | Port 1 thread tag |
| p1_cls | output | 3 | Port 1 class code |
| p1_op | output | OPW | Port 1 payload |

## Verification
The bench builds the block with DEPTH = 4 and OPW = 8. The shallow queue lets a few two-lane intake cycles fill a thread completely. That brings the lane-1 room rule, full-thread refusal and refusal on a single lane within reach. A long random phase also hits the full condition often. The 8-bit payload carries a running sequence number, so any reordering within a thread shows up as a wrong payload on a port. A mid-run reset that follows random traffic checks that the favour returns to thread 0 whatever its state was before.

// File: rtl/sched_pkg.sv
package sched_pkg;

   localparam int CLSW  = 3;
   localparam int NTHR  = 2;
   localparam int NPORT = 2;

   typedef enum logic [CLSW-1:0] {
      CLS_ALU = 3'd0,
      CLS_SHF = 3'd1,
      CLS_MEM = 3'd2,
      CLS_BIT = 3'd3,
      CLS_JMP = 3'd4,
      CLS_LEA = 3'd5,
      CLS_V64 = 3'd6,
      CLS_FAM = 3'd7
   } cls_e;

   function automatic logic fits_p0(input logic [CLSW-1:0] c);
      return (c == CLS_ALU) || (c == CLS_SHF) || (c == CLS_MEM) || (c == CLS_V64);
   endfunction

   function automatic logic fits_p1(input logic [CLSW-1:0] c);
      return (c == CLS_ALU) || (c == CLS_BIT) || (c == CLS_JMP) || (c == CLS_LEA);
   endfunction

   function automatic logic is_dual(input logic [CLSW-1:0] c);
      return c == CLS_FAM;
   endfunction

endpackage

// File: rtl/sched_tq.sv
module sched_tq #(
   parameter int DEPTH = 8,
   parameter int EW    = 11,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [1:0]    push_n,
   input  logic [EW-1:0] push_a,
   input  logic [EW-1:0] push_b,
   input  logic [1:0]    pop_n,
   output logic [EW-1:0] head,
   output logic [EW-1:0] nxt,
   output logic [CW-1:0] cnt
);

   logic [EW-1:0] mem [DEPTH];
   logic [AW-1:0] rd_q;
   logic [AW-1:0] wr_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (push_n != 2'd0) mem[wr_q] <= push_a;
      if (push_n == 2'd2) mem[wr_q + AW'(1)] <= push_b;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         wr_q  <= wr_q + AW'(push_n);
         rd_q  <= rd_q + AW'(pop_n);
         cnt_q <= cnt_q + CW'(push_n) - CW'(pop_n);
      end
   end

   assign head = mem[rd_q];
   assign nxt  = mem[rd_q + AW'(1)];
   assign cnt  = cnt_q;

endmodule

// File: rtl/sched_intake.sv
module sched_intake #(
   parameter int DEPTH = 8,
   parameter int OPW   = 8,
   localparam int EW   = OPW + sched_pkg::CLSW,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic [1:0]       in_valid,
   input  logic [1:0]       in_tid,
   input  logic [5:0]       in_cls,
   input  logic [2*OPW-1:0] in_op,
   input  logic [CW-1:0]    cnt [2],
   output logic [1:0]       in_ready,
   output logic [1:0]       push_n [2],
   output logic [EW-1:0]    push_a [2],
   output logic [EW-1:0]    push_b [2]
);

   logic [EW-1:0] lane_e [2];
   logic          room0;
   logic          room1;
   logic [CW:0]   need1;
   logic [1:0]    acc;

   assign lane_e[0] = {in_cls[2:0], in_op[OPW-1:0]};
   assign lane_e[1] = {in_cls[5:3], in_op[2*OPW-1:OPW]};

   always_comb begin
      room0 = cnt[in_tid[0]] < CW'(DEPTH);
      need1 = {1'b0, cnt[in_tid[1]]}
              + (CW+1)'(in_valid[0] && room0 && (in_tid[0] == in_tid[1]));
      room1 = need1 < (CW+1)'(DEPTH);
   end

   assign in_ready = {room1, room0};
   assign acc      = in_valid & in_ready;

   for (genvar t = 0; t < 2; t++) begin : g_route
      always_comb begin
         push_n[t] = 2'd0;
         push_a[t] = lane_e[0];
         push_b[t] = lane_e[1];
         if (acc[0] && (in_tid[0] == 1'(t))) push_n[t] = 2'd1;
         if (acc[1] && (in_tid[1] == 1'(t))) begin
            if (push_n[t] == 2'd1) begin
               push_n[t] = 2'd2;
            end else begin
               push_n[t] = 2'd1;
               push_a[t] = lane_e[1];
            end
         end
      end
   end

endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
   parameter int OPW  = 8,
   localparam int EW  = OPW + sched_pkg::CLSW
) (
   input  logic [EW-1:0] head [2],
   input  logic [EW-1:0] nxt  [2],
   input  logic [1:0]    has1,
   input  logic [1:0]    has2,
   input  logic [1:0]    thr_rdy,
   input  logic          rr,
   output logic [1:0]    pv,
   output logic [EW-1:0] pe [2],
   output logic [1:0]    pt,
   output logic [1:0]    pop_n [2],
   output logic          contend
);
   import sched_pkg::*;

   function automatic logic port_ok(input logic [EW-1:0] e, input logic p);
      logic [CLSW-1:0] c;
      c = e[EW-1 -: CLSW];
      if (is_dual(c)) return 1'b0;
      return p ? fits_p1(c) : fits_p0(c);
   endfunction

   logic [1:0]      elig;
   logic            f;
   logic            fv;
   logic            o;
   logic            p1st;
   logic            pfree;
   logic [CLSW-1:0] c1st;

   assign elig    = thr_rdy & has1;
   assign contend = elig[0] & elig[1];

   always_comb begin
      fv = 1'b1;
      f  = rr;
      if (!elig[rr]) begin
         f  = ~rr;
         fv = elig[~rr];
      end
      o     = ~f;
      c1st  = head[f][EW-1 -: CLSW];
      p1st  = fits_p1(c1st);
      pfree = ~p1st;

      pv       = 2'b00;
      pt       = 2'b00;
      pe[0]    = head[f];
      pe[1]    = head[f];
      pop_n[0] = 2'd0;
      pop_n[1] = 2'd0;

      if (fv) begin
         pop_n[f] = 2'd1;
         if (is_dual(c1st)) begin
            pv = 2'b11;
            pt = {f, f};
         end else begin
            pv[p1st] = 1'b1;
            pt[p1st] = f;
            pe[p1st] = head[f];
            if (elig[o] && port_ok(head[o], pfree)) begin
               pv[pfree] = 1'b1;
               pt[pfree] = o;
               pe[pfree] = head[o];
               pop_n[o]  = 2'd1;
            end else if (has2[f] && port_ok(nxt[f], pfree)) begin
               pv[pfree] = 1'b1;
               pt[pfree] = f;
               pe[pfree] = nxt[f];
               pop_n[f]  = 2'd2;
            end
         end
      end
   end

endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched #(
   parameter int DEPTH = 8,
   parameter int OPW   = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       in_valid,
   input  logic [1:0]       in_tid,
   input  logic [5:0]       in_cls,
   input  logic [2*OPW-1:0] in_op,
   output logic [1:0]       in_ready,
   input  logic [1:0]       thr_rdy,
   output logic             p0_valid,
   output logic             p0_tid,
   output logic [2:0]       p0_cls,
   output logic [OPW-1:0]   p0_op,
   output logic             p1_valid,
   output logic             p1_tid,
   output logic [2:0]       p1_cls,
   output logic [OPW-1:0]   p1_op
);
   import sched_pkg::*;

   localparam int EW = OPW + CLSW;
   localparam int CW = $clog2(DEPTH) + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dual_issue_sched: DEPTH must be a power of two of at least 2");
   end
   if (OPW < 1) begin : g_bad_opw
      $error("dual_issue_sched: OPW must be at least 1");
   end

   logic [CW-1:0] cnt    [NTHR];
   logic [EW-1:0] head   [NTHR];
   logic [EW-1:0] nxt    [NTHR];
   logic [1:0]    push_n [NTHR];
   logic [EW-1:0] push_a [NTHR];
   logic [EW-1:0] push_b [NTHR];
   logic [1:0]    pop_n  [NTHR];
   logic [1:0]    has1;
   logic [1:0]    has2;
   logic [1:0]    pv;
   logic [1:0]    pt;
   logic [EW-1:0] pe     [NPORT];
   logic          contend;
   logic          rr_q;

   sched_intake #(.DEPTH(DEPTH), .OPW(OPW)) u_intake (
      .in_valid (in_valid),
      .in_tid   (in_tid),
      .in_cls   (in_cls),
      .in_op    (in_op),
      .cnt      (cnt),
      .in_ready (in_ready),
      .push_n   (push_n),
      .push_a   (push_a),
      .push_b   (push_b)
   );

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      sched_tq #(.DEPTH(DEPTH), .EW(EW)) u_tq (
         .clk    (clk),
         .rst    (rst),
         .push_n (push_n[t]),
         .push_a (push_a[t]),
         .push_b (push_b[t]),
         .pop_n  (pop_n[t]),
         .head   (head[t]),
         .nxt    (nxt[t]),
         .cnt    (cnt[t])
      );
      assign has1[t] = cnt[t] != '0;
      assign has2[t] = cnt[t] > CW'(1);
   end

   sched_pick #(.OPW(OPW)) u_pick (
      .head    (head),
      .nxt     (nxt),
      .has1    (has1),
      .has2    (has2),
      .thr_rdy (thr_rdy),
      .rr      (rr_q),
      .pv      (pv),
      .pe      (pe),
      .pt      (pt),
      .pop_n   (pop_n),
      .contend (contend)
   );

   always_ff @(posedge clk) begin
      if (rst)          rr_q <= 1'b0;
      else if (contend) rr_q <= ~rr_q;
   end

   assign p0_valid = pv[0];
   assign p0_tid   = pt[0];
   assign p0_cls   = pe[0][EW-1 -: CLSW];
   assign p0_op    = pe[0][OPW-1:0];
   assign p1_valid = pv[1];
   assign p1_tid   = pt[1];
   assign p1_cls   = pe[1][EW-1 -: CLSW];
   assign p1_op    = pe[1][OPW-1:0];

endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
   parameter int OPW = 8
) (
   input logic           clk,
   input logic           rst,
   input logic [1:0]     thr_rdy,
   input logic           p0_valid,
   input logic           p0_tid,
   input logic [2:0]     p0_cls,
   input logic [OPW-1:0] p0_op,
   input logic           p1_valid,
   input logic           p1_tid,
   input logic [2:0]     p1_cls,
   input logic [OPW-1:0] p1_op
);
   import sched_pkg::*;

   // R6
   fam_dual_chk: assert property (@(posedge clk) disable iff (rst)
      (p0_valid && p0_cls == CLS_FAM) |->
      (p1_valid && p1_cls == CLS_FAM && p1_tid == p0_tid && p1_op == p0_op));

   // R4
   p0_class_chk: assert property (@(posedge clk) disable iff (rst)
      p0_valid |-> (fits_p0(p0_cls) || p0_cls == CLS_FAM));

   // R4
   p1_class_chk: assert property (@(posedge clk) disable iff (rst)
      p1_valid |-> (fits_p1(p1_cls) || p1_cls == CLS_FAM));

   // R5
   v64_port0_chk: assert property (@(posedge clk) disable iff (rst)
      p1_valid |-> (p1_cls != CLS_V64));

   // R7
   idle_p0_chk: assert property (@(posedge clk) disable iff (rst)
      p0_valid |-> thr_rdy[p0_tid]);

   // R7
   idle_p1_chk: assert property (@(posedge clk) disable iff (rst)
      p1_valid |-> thr_rdy[p1_tid]);

   // R11
   reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!p0_valid && !p1_valid));

endmodule

bind dual_issue_sched sched_chk #(.OPW(OPW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .thr_rdy  (thr_rdy),
   .p0_valid (p0_valid),
   .p0_tid   (p0_tid),
   .p0_cls   (p0_cls),
   .p0_op    (p0_op),
   .p1_valid (p1_valid),
   .p1_tid   (p1_tid),
   .p1_cls   (p1_cls),
   .p1_op    (p1_op)
);

// File: tb/dual_issue_sched_test.sv
module dual_issue_sched_test;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int OPW        = 8;
   localparam int EW         = OPW + 3;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [1:0]       in_valid = '0;
   logic [1:0]       in_tid = '0;
   logic [5:0]       in_cls = '0;
   logic [2*OPW-1:0] in_op = '0;
   logic [1:0]       in_ready;
   logic [1:0]       thr_rdy = '0;
   logic             p0_valid, p0_tid, p1_valid, p1_tid;
   logic [2:0]       p0_cls, p1_cls;
   logic [OPW-1:0]   p0_op, p1_op;

   int checks = 0;
   int errors = 0;

   logic [EW-1:0] mq [2][$];
   int            m_rr = 0;
   logic [OPW-1:0] seq = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_issue_sched #(.DEPTH(DEPTH), .OPW(OPW)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_tid(in_tid),
      .in_cls(in_cls), .in_op(in_op), .in_ready(in_ready), .thr_rdy(thr_rdy),
      .p0_valid(p0_valid), .p0_tid(p0_tid), .p0_cls(p0_cls), .p0_op(p0_op),
      .p1_valid(p1_valid), .p1_tid(p1_tid), .p1_cls(p1_cls), .p1_op(p1_op)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   function automatic bit m_ok(input logic [EW-1:0] e, input int p);
      logic [2:0] c;
      c = e[EW-1 -: 3];
      if (c == 3'd7) return 1'b0;
      if (p == 1) return c inside {3'd0, 3'd3, 3'd4, 3'd5};
      return c inside {3'd0, 3'd1, 3'd2, 3'd6};
   endfunction

   // One clock: drive, compare against the model, advance the model.
   task automatic step(input string tag, input logic [1:0] v, input logic [1:0] tid,
                       input logic [2:0] c0, input logic [2:0] c1, input logic [1:0] rdy);
      int sz[2];
      bit el[2];
      bit ev[2];
      int et[2];
      logic [EW-1:0] ee[2];
      int pop[2];
      int f;
      bit r0, r1;
      logic [EW-1:0] l0, l1;
      l0 = {c0, seq};
      l1 = {c1, seq + OPW'(1)};
      in_valid = v; in_tid = tid; in_cls = {c1, c0}; in_op = {l1[OPW-1:0], l0[OPW-1:0]};
      thr_rdy = rdy;
      #1;
      for (int t = 0; t < 2; t++) begin
         sz[t] = mq[t].size(); el[t] = rdy[t] && sz[t] > 0;
         ev[t] = 0; et[t] = 0; ee[t] = '0; pop[t] = 0;
      end
      r0 = sz[tid[0]] < DEPTH;
      r1 = (sz[tid[1]] + ((v[0] && r0 && tid[0] == tid[1]) ? 1 : 0)) < DEPTH;
      f = -1;
      if (el[m_rr]) f = m_rr;
      else if (el[1-m_rr]) f = 1 - m_rr;
      if (f >= 0) begin
         logic [EW-1:0] h;
         h = mq[f][0];
         pop[f] = 1;
         if (h[EW-1 -: 3] == 3'd7) begin
            ev[0] = 1; ev[1] = 1; et[0] = f; et[1] = f; ee[0] = h; ee[1] = h;
         end else begin
            int p, fp, o;
            p = m_ok(h, 1) ? 1 : 0;
            fp = 1 - p; o = 1 - f;
            ev[p] = 1; et[p] = f; ee[p] = h;
            if (el[o] && m_ok(mq[o][0], fp)) begin
               ev[fp] = 1; et[fp] = o; ee[fp] = mq[o][0]; pop[o] = 1;
            end else if (sz[f] >= 2 && m_ok(mq[f][1], fp)) begin
               ev[fp] = 1; et[fp] = f; ee[fp] = mq[f][1]; pop[f] = 2;
            end
         end
      end
      chk({tag, " in_ready"}, {30'd0, in_ready}, {30'd0, r1, r0});
      chk({tag, " port0"}, p0_valid ? {20'd0, 1'b1, p0_tid, p0_cls, p0_op} : 32'd0,
          ev[0] ? {20'd0, 1'b1, 1'(et[0]), ee[0]} : 32'd0);
      chk({tag, " port1"}, p1_valid ? {20'd0, 1'b1, p1_tid, p1_cls, p1_op} : 32'd0,
          ev[1] ? {20'd0, 1'b1, 1'(et[1]), ee[1]} : 32'd0);
      @(posedge clk);
      for (int t = 0; t < 2; t++)
         for (int k = 0; k < pop[t]; k++) void'(mq[t].pop_front());
      if (v[0] && r0) mq[tid[0]].push_back(l0);
      if (v[1] && r1) mq[tid[1]].push_back(l1);
      if (el[0] && el[1]) m_rr = 1 - m_rr;
      seq = seq + OPW'(2);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1; in_valid = '0; thr_rdy = '0;
      repeat (2) @(posedge clk);
      mq[0].delete(); mq[1].delete(); m_rr = 0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R3: watchdog expired, actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R11: empty after reset, both lanes ready, nothing issues
      step("R11", 2'b00, 2'b00, 3'd0, 3'd0, 2'b11);
      // R2: fill thread 0 through both lanes, third pair refused
      step("R2", 2'b11, 2'b00, 3'd0, 3'd0, 2'b00);
      step("R2", 2'b11, 2'b00, 3'd0, 3'd0, 2'b00);
      step("R2", 2'b11, 2'b00, 3'd0, 3'd0, 2'b00);
      step("R2", 2'b11, 2'b10, 3'd0, 3'd3, 2'b00);
      // R1: lane 1 room counts lane 0
      step("R1", 2'b11, 2'b11, 3'd4, 3'd5, 2'b00);
      step("R1", 2'b11, 2'b11, 3'd0, 3'd1, 2'b00);
      // R3: thread 0 alone drains in order, two per cycle
      for (int i = 0; i < 3; i++) step("R3", 2'b00, 2'b00, 3'd0, 3'd0, 2'b01);
      // R10: thread 1 alone
      for (int i = 0; i < 3; i++) step("R10", 2'b00, 2'b00, 3'd0, 3'd0, 2'b10);
      // R5 / R4: port-restricted classes from both threads
      step("R5", 2'b11, 2'b10, 3'd6, 3'd6, 2'b00);
      step("R5", 2'b11, 2'b10, 3'd4, 3'd1, 2'b00);
      for (int i = 0; i < 3; i++) step("R5", 2'b00, 2'b00, 3'd0, 3'd0, 2'b11);
      step("R4", 2'b11, 2'b00, 3'd2, 3'd6, 2'b00);
      step("R4", 2'b11, 2'b11, 3'd3, 3'd1, 2'b00);
      for (int i = 0; i < 4; i++) step("R4", 2'b00, 2'b00, 3'd0, 3'd0, 2'b11);
      // R6: dual-port FP add blocks everything else that cycle
      step("R6", 2'b11, 2'b00, 3'd7, 3'd0, 2'b00);
      step("R6", 2'b11, 2'b11, 3'd0, 3'd7, 2'b00);
      for (int i = 0; i < 4; i++) step("R6", 2'b00, 2'b00, 3'd0, 3'd0, 2'b11);
      // R7: held thread keeps its entries
      step("R7", 2'b11, 2'b10, 3'd0, 3'd0, 2'b00);
      step("R7", 2'b11, 2'b10, 3'd1, 3'd4, 2'b00);
      for (int i = 0; i < 2; i++) step("R7", 2'b00, 2'b00, 3'd0, 3'd0, 2'b10);
      for (int i = 0; i < 2; i++) step("R7", 2'b00, 2'b00, 3'd0, 3'd0, 2'b00);
      for (int i = 0; i < 2; i++) step("R7", 2'b00, 2'b00, 3'd0, 3'd0, 2'b01);
      // R8: both threads loaded with port-0-only work, favour alternates
      step("R8", 2'b11, 2'b00, 3'd1, 3'd2, 2'b00);
      step("R8", 2'b11, 2'b11, 3'd6, 3'd1, 2'b00);
      step("R8", 2'b11, 2'b11, 3'd2, 3'd2, 2'b00);
      for (int i = 0; i < 6; i++) step("R8", 2'b00, 2'b00, 3'd0, 3'd0, 2'b11);
      // R9: random traffic
      for (int i = 0; i < 600; i++)
         step("R9", 2'($urandom), 2'($urandom), 3'($urandom), 3'($urandom),
              ($urandom % 4 == 0) ? 2'($urandom) : 2'b11);
      // R11: mid-run reset restores favour to thread 0
      do_reset();
      step("R11", 2'b11, 2'b10, 3'd1, 3'd1, 2'b00);
      for (int i = 0; i < 3; i++) step("R11", 2'b00, 2'b00, 3'd0, 3'd0, 2'b11);
      summary();
      $finish;
   end

endmodule